// File: doc/BRIEF.md
# Addressable Scan State Array

This block is a bank of state flip-flops that are accessed for test one cell at a time, by address, rather than by shifting a serial chain. In functional operation every cell loads its own bit of the functional data vector on each clock, and the whole bank appears on the state output vector.

For test access a small address register is loaded serially, one bit per clock, while its shift enable is high. A decoder turns that address into a select for a single cell. With scan mode asserted, only the selected cell takes the serial scan input on the clock, and every other cell keeps its value. The scan output always presents the selected cell's present content without needing a clock edge, so one bit can be read or changed without disturbing the rest. Writing one bit and then giving one functional clock forms a single-input-change step for the logic behind the bank.

Top module: `ras_array`

## Requirements
- R1: While rst_ni is low, every cell and every address bit reads 0, so state_q_o is all zeros and scan_out_o is 0.
- R2: On a clock with addr_shift_i high, the address register shifts left by one and takes addr_sin_i into bit 0, so an address is sent most significant bit first; with addr_shift_i low the address is unchanged.
- R3: An address below N_CELLS selects exactly one cell, the cell with that index; an address of N_CELLS or more selects no cell.
- R4: With scan_en_i low, every cell loads its bit of func_d_i on the clock, whatever the address.
- R5: With scan_en_i high, the selected cell loads scan_in_i on the clock.
- R6: With scan_en_i high, every cell that is not selected keeps its value.
- R7: scan_out_o equals the current value of the selected cell without waiting for a clock, and reads 0 when the address is N_CELLS or more.
- R8: With scan_en_i high and an address of N_CELLS or more, no cell changes.
- R9: Writing one cell in scan mode and then applying one clock with scan_en_i low leaves state_q_o equal to func_d_i from that clock, so a single bit can be set before one functional capture.
- R10: The cell select in use on a clock is the address held before that clock, so shifting the address and writing in scan mode on the same clock writes the old address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the cells and the address register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scan_en_i | input | 1 | 1 = scan mode (addressed write), 0 = functional capture |
| func_d_i | input | N_CELLS | Functional data, one bit per cell |
| state_q_o | output | N_CELLS | Current contents of all cells |
| scan_in_i | input | 1 | Serial data written to the selected cell in scan mode |
| scan_out_o | output | 1 | Value of the selected cell, 0 when no cell is selected |
| addr_sin_i | input | 1 | Serial address bit, most significant first |
| addr_shift_i | input | 1 | Shift enable for the address register |

## Verification
The assertions take for granted that all inputs are stable around the rising clock edge and that reset is held for at least one edge; they make no assumption on the address value, so out-of-range codes are legal inputs. The stimulus changes inputs only on the falling edge, walks the address through every in-range and out-of-range code, and mixes address shifting with scan writes and functional captures on the same clock, so the reference model in the bench sees each combination the assertions rely on.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    MODE_FUNC = 1'b0,
    MODE_SCAN = 1'b1
  } ras_mode_e;
endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg #(
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sin_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  generate
    if (ADDR_W == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= sin_i;
      end
    end else begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      addr_q <= '0;
        else if (shift_i) addr_q <= {addr_q[ADDR_W-2:0], sin_i};
      end
    end
  endgenerate

  assign addr_o = addr_q;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(addr_o));
  p_addr_lsb_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> addr_o[0] == $past(sin_i));
endmodule

// File: rtl/ras_addr_decode.sv
module ras_addr_decode #(
  parameter int N_CELLS = 6,
  parameter int ADDR_W  = 3
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [N_CELLS-1:0] sel_o
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end

  always_comb begin
    p_sel_onehot0_r3: assert ($onehot0(sel_o));
    if (int'(addr_i) < N_CELLS) begin
      p_sel_one_r3: assert ($countones(sel_o) == 1);
    end else begin
      p_sel_none_r3: assert (sel_o == '0);
    end
  end
endmodule

// File: rtl/ras_cell.sv
module ras_cell
  import ras_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ras_mode_e mode_i,
  input  logic      sel_i,
  input  logic      d_i,
  input  logic      sd_i,
  output logic      q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= 1'b0;
    else if (mode_i == MODE_FUNC) q_q <= d_i;
    else if (sel_i)             q_q <= sd_i;
  end

  assign q_o = q_q;

  p_func_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FUNC) |=> q_o == $past(d_i));
  p_scan_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SCAN && sel_i) |=> q_o == $past(sd_i));
  p_unsel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SCAN && !sel_i) |=> $stable(q_o));
endmodule

// File: rtl/ras_array.sv
module ras_array
  import ras_pkg::*;
#(
  parameter int N_CELLS = 6,
  localparam int ADDR_W = (N_CELLS > 2) ? $clog2(N_CELLS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scan_en_i,
  input  logic [N_CELLS-1:0] func_d_i,
  output logic [N_CELLS-1:0] state_q_o,
  input  logic               scan_in_i,
  output logic               scan_out_o,
  input  logic               addr_sin_i,
  input  logic               addr_shift_i
);
  logic [ADDR_W-1:0]  addr;
  logic [N_CELLS-1:0] sel;
  ras_mode_e          mode;

  assign mode = ras_mode_e'(scan_en_i);

  ras_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (addr_shift_i),
    .sin_i   (addr_sin_i),
    .addr_o  (addr)
  );

  ras_addr_decode #(.N_CELLS(N_CELLS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr),
    .sel_o  (sel)
  );

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    ras_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .sel_i  (sel[i]),
      .d_i    (func_d_i[i]),
      .sd_i   (scan_in_i),
      .q_o    (state_q_o[i])
    );
  end

  // AND-OR read path: no select means 0
  always_comb begin
    scan_out_o = 1'b0;
    for (int i = 0; i < N_CELLS; i++) scan_out_o = scan_out_o | (sel[i] & state_q_o[i]);
  end

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (state_q_o == '0 && addr == '0));
  p_so_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr) >= N_CELLS) |-> !scan_out_o);
  p_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_en_i && int'(addr) >= N_CELLS) |=> $stable(state_q_o));
endmodule

// File: tb/ras_array_bench.sv
`timescale 1ns/1ps
module ras_array_bench;
  localparam int N  = 6;
  localparam int AW = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         scan_en = 1'b0;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] state_q;
  logic         scan_in = 1'b0;
  logic         scan_out;
  logic         addr_sin = 1'b0;
  logic         addr_shift = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_state = '0;
  int           m_addr = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  ras_array #(.N_CELLS(N)) u_ras_array (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .scan_en_i    (scan_en),
    .func_d_i     (func_d),
    .state_q_o    (state_q),
    .scan_in_i    (scan_in),
    .scan_out_o   (scan_out),
    .addr_sin_i   (addr_sin),
    .addr_shift_i (addr_shift)
  );

  task automatic compare(input string req);
    logic exp_so;
    exp_so = (m_addr < N) ? m_state[m_addr] : 1'b0;
    checks++;
    if (state_q !== m_state) begin
      errors++;
      $display("FAIL %s state_q actual=%b expected=%b", req, state_q, m_state);
    end
    checks++;
    if (scan_out !== exp_so) begin
      errors++;
      $display("FAIL %s scan_out actual=%b expected=%b (addr %0d)", req, scan_out, exp_so, m_addr);
    end
  endtask

  task automatic step(input logic se, input logic [N-1:0] d, input logic si,
                      input logic sh, input logic as, input string req);
    scan_en = se; func_d = d; scan_in = si; addr_shift = sh; addr_sin = as;
    @(posedge clk);
    if (se) begin
      if (m_addr < N) m_state[m_addr] = si;
    end else begin
      m_state = d;
    end
    if (sh) m_addr = ((m_addr << 1) | int'(as)) & ((1 << AW) - 1);
    @(negedge clk);
    compare(req);
  endtask

  // shift a full address MSB first; cells capture their current state
  task automatic load_addr(input int a, input string req);
    for (int b = AW - 1; b >= 0; b--) step(1'b0, m_state, 1'b0, 1'b1, a[b], req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1");

    // R4: functional capture regardless of address
    step(1'b0, 6'b101010, 1'b1, 1'b0, 1'b0, "R4");
    step(1'b0, 6'b010101, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 6'b111111, 1'b0, 1'b0, 1'b0, "R4");
    step(1'b0, 6'b000110, 1'b1, 1'b0, 1'b0, "R4");

    // R2/R3/R5/R6/R7: walk every valid address and write
    for (int a = 0; a < N; a++) begin
      load_addr(a, "R2");
      step(1'b1, 6'b111111, ~m_state[a], 1'b0, 1'b0, "R5");
      step(1'b1, 6'b000000, 1'b1, 1'b0, 1'b0, "R6");
      step(1'b0, 6'b110011 ^ 6'(a), 1'b0, 1'b0, 1'b0, "R3");
    end

    // R7/R8: out-of-range codes select nothing
    for (int a = N; a < (1 << AW); a++) begin
      load_addr(a, "R2");
      step(1'b1, 6'b000000, 1'b1, 1'b0, 1'b0, "R8");
      step(1'b1, 6'b111111, 1'b0, 1'b0, 1'b0, "R7");
    end

    // R2: address holds while shift is low across scan writes
    load_addr(4, "R2");
    for (int k = 0; k < 4; k++) step(1'b1, 6'b0, k[0], 1'b0, 1'b1, "R2");

    // R10: shift and scan write on the same clock use the old address
    load_addr(1, "R10");
    step(1'b1, 6'b0, 1'b1, 1'b1, 1'b0, "R10");
    step(1'b1, 6'b0, 1'b0, 1'b1, 1'b1, "R10");

    // R9: single-input-change step
    load_addr(2, "R9");
    step(1'b1, 6'b0, 1'b1, 1'b0, 1'b0, "R9");
    step(1'b0, 6'b100100, 1'b0, 1'b0, 1'b0, "R9");
    load_addr(5, "R9");
    step(1'b1, 6'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(1'b0, 6'b011011, 1'b1, 1'b0, 1'b0, "R9");

    // mixed traffic
    for (int k = 0; k < 200; k++) begin
      step(1'($urandom), 6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R5");
    end

    // R1: asynchronous reset clears everything again
    @(negedge clk);
    #3 rst_ni = 1'b0;
    m_state = '0; m_addr = 0;
    #2 compare("R1");
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule